// File: doc/BRIEF.md
# Lane-Striped Vector Tree Reducer

This block reduces a vector of up to 63 sixteen-bit elements to one value, using a selectable associative operation: wrapping add, AND, OR or XOR. The vector sits in a register file whose registers each carry two elements. Consecutive registers feed consecutive lane pairs of an eight-lane datapath, so element i always lands in lane i mod 8. A start pulse latches the element count and the operation. The block then reads four registers per cycle and folds each lane's elements into that lane's accumulator. Elements from higher registers join the same lane's accumulator without leaving it.

After folding, three tree levels run, one per clock. At each level every surviving lane combines its value with one neighbour at a fixed distance: first stride 1, then stride 2, then stride 4. No lane ever needs a general lane-crossing network. The final value ends in lane 0, which is element 0 of register 0. It is presented on `result` together with a one-cycle `done` and write strobe.

The result side carries no back-pressure. The write strobe lasts exactly one cycle and has no ready, so the register file must accept the write in that cycle. The read side is a plain combinational read: `rd_data` must reflect `rd_addr` within the same cycle while `rd_en` is high.

Top module: `tree_vec_reducer`

## Requirements
- R1: After reset, `done`, `wb_we` and `rd_en` are low and `result` is zero.
- R2: When `done` is high, `result` is the serial reduction of elements 0..N-1. The `op` encoding is 0 = add modulo 2^16, 1 = AND, 2 = OR and 3 = XOR.
- R3: Element i is half i mod 2 of register i/2, with half 0 in bits 15:0 and half 1 in bits 31:16. During fold pass k, read port j (bits j*5 +: 5 of `rd_addr`, data in bits j*32 +: 32 of `rd_data`) addresses register 4k+j, and `rd_en` is high.
- R4: Elements with index N or above have no effect on the result, including when N is not a multiple of 8.
- R5: With N = 0 the result is the operation's identity: 0 for add, OR and XOR, and 0xFFFF for AND.
- R6: `done` goes high exactly P+3 clock edges after the edge that samples `start`, where P = max(1, ceil(N/8)).
- R7: `done` lasts one cycle, and `wb_we` is high in exactly the cycles where `done` is high.
- R8: A `start` pulse while a reduction is in progress is ignored. Its count and operation do not affect the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reduction (sampled when idle) |
| n_elems | input | 6 | Element count N |
| op | input | 2 | Operation select |
| rd_en | output | 1 | Fold pass in progress, read ports active |
| rd_addr | output | 20 | Four 5-bit register read addresses |
| rd_data | input | 128 | Four 32-bit register read data words |
| result | output | 16 | Reduced value (lane 0 accumulator) |
| done | output | 1 | One-cycle completion pulse |
| wb_we | output | 1 | Write strobe for register 0, element 0 |

## Verification
The bench sweeps every count from 0 to 32 plus 63 under all four operations, with random data beyond N. A design that fails to mask tail lanes would fold stray elements into counts such as 13 or 31. A wrong identity would corrupt AND at N = 0 or on short vectors. A misrouted tree stride would mix the wrong lane pairs and break nearly every count. The bench fires a second start mid-run with a different count and operation: a design that re-latches would return the wrong reduction. It also checks the exact done cycle for one-pass and multi-pass counts, and it checks the read addresses on every fold pass.

// File: rtl/tree_red_pkg.sv
package tree_red_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_AND = 2'd1,
    OP_OR  = 2'd2,
    OP_XOR = 2'd3
  } red_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FOLD = 2'd1,
    ST_TREE = 2'd2
  } red_state_e;
endpackage

// File: rtl/tvr_ctrl.sv
module tvr_ctrl
  import tree_red_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int N_W    = 6,
  parameter int LB     = 3,
  parameter int LEVELS = 3,
  parameter int PASS_W = 4,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N_W-1:0]    n_in,
  input  logic [1:0]        op_in,
  output logic              init,
  output logic              fold_act,
  output logic [PASS_W-1:0] pass_q,
  output logic              tree_act,
  output logic [LVL_W-1:0]  lvl_q,
  output logic [N_W-1:0]    n_q,
  output red_op_e           op_q,
  output logic              done
);
  red_state_e        state;
  logic [PASS_W-1:0] npass_q;
  logic [N_W:0]      n_round;
  logic [PASS_W-1:0] npass_d;

  assign n_round = {1'b0, n_in} + (N_W + 1)'(LANES - 1);
  assign npass_d = (n_round[N_W:LB] == '0) ? PASS_W'(1) : PASS_W'(n_round[N_W:LB]);

  assign init     = (state == ST_IDLE) && start;
  assign fold_act = (state == ST_FOLD);
  assign tree_act = (state == ST_TREE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pass_q  <= '0;
      npass_q <= PASS_W'(1);
      lvl_q   <= '0;
      n_q     <= '0;
      op_q    <= OP_ADD;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state   <= ST_FOLD;
          pass_q  <= '0;
          npass_q <= npass_d;
          n_q     <= n_in;
          op_q    <= red_op_e'(op_in);
        end
        ST_FOLD: begin
          if (pass_q == npass_q - PASS_W'(1)) begin
            state <= ST_TREE;
            lvl_q <= '0;
          end else begin
            pass_q <= pass_q + PASS_W'(1);
          end
        end
        ST_TREE: begin
          if (lvl_q == LVL_W'(LEVELS - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            lvl_q <= lvl_q + LVL_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_TREE_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tree_act && lvl_q == LVL_W'(LEVELS - 1)) |=> (done && !tree_act && !fold_act)); // R6
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start) |=> ($stable(n_q) && $stable(op_q))); // R8
  AST_PASS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fold_act |-> (pass_q < npass_q)); // R3
endmodule

// File: rtl/tvr_lane.sv
module tvr_lane
  import tree_red_pkg::*;
#(
  parameter int ELEM_W  = 16,
  parameter bit IS_EVEN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic [ELEM_W-1:0] init_val,
  input  logic              fold_take,
  input  logic [ELEM_W-1:0] fold_elem,
  input  logic              tree_take,
  input  logic [ELEM_W-1:0] partner,
  input  red_op_e           op,
  output logic [ELEM_W-1:0] acc
);
  function automatic logic [ELEM_W-1:0] combine(input logic [ELEM_W-1:0] a,
                                                input logic [ELEM_W-1:0] b,
                                                input red_op_e o);
    case (o)
      OP_ADD:  combine = a + b;
      OP_AND:  combine = a & b;
      OP_OR:   combine = a | b;
      default: combine = a ^ b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)         acc <= '0;
    else if (init)      acc <= init_val;
    else if (fold_take) acc <= combine(acc, fold_elem, op);
    else if (tree_take) acc <= combine(acc, partner, op);
  end

  AST_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(init || fold_take || tree_take) |=> $stable(acc)); // R4
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fold_take && tree_take)); // R3

  if (!IS_EVEN) begin : g_odd
    AST_ODD_NEVER_RECEIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !tree_take); // R2
  end
endmodule

// File: rtl/tree_vec_reducer.sv
module tree_vec_reducer
  import tree_red_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int ELEM_W = 16,
  parameter int N_W    = 6,
  parameter int AW     = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [N_W-1:0]               n_elems,
  input  logic [1:0]                   op,
  output logic                         rd_en,
  output logic [(LANES/2)*AW-1:0]      rd_addr,
  input  logic [(LANES/2)*2*ELEM_W-1:0] rd_data,
  output logic [ELEM_W-1:0]            result,
  output logic                         done,
  output logic                         wb_we
);
  localparam int LB     = $clog2(LANES);
  localparam int LEVELS = LB;
  localparam int RP     = LANES / 2;
  localparam int REG_W  = 2 * ELEM_W;
  localparam int PASS_W = N_W - LB + 1;
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int IDX_W  = N_W + 1;

  logic              init, fold_act, tree_act;
  logic [PASS_W-1:0] pass_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [N_W-1:0]    n_q;
  red_op_e           op_q;
  logic [ELEM_W-1:0] init_val;
  logic [ELEM_W-1:0] acc [LANES];

  tvr_ctrl #(
    .LANES(LANES), .N_W(N_W), .LB(LB), .LEVELS(LEVELS),
    .PASS_W(PASS_W), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_elems), .op_in(op),
    .init(init), .fold_act(fold_act), .pass_q(pass_q), .tree_act(tree_act),
    .lvl_q(lvl_q), .n_q(n_q), .op_q(op_q), .done(done)
  );

  always_comb begin
    init_val = (red_op_e'(op) == OP_AND) ? '1 : '0;
  end

  for (genvar j = 0; j < RP; j++) begin : g_port
    assign rd_addr[j*AW +: AW] = AW'(32'(pass_q) * RP + j);
  end

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    logic [IDX_W-1:0]              idx;
    logic                          fold_take;
    logic                          tree_take;
    logic [LEVELS-1:0][ELEM_W-1:0] pv;
    logic [LEVELS-1:0]             has;

    assign idx       = (IDX_W'(pass_q) << LB) + IDX_W'(L);
    assign fold_take = fold_act && (idx < {1'b0, n_q});

    for (genvar t = 0; t < LEVELS; t++) begin : g_lvl
      if ((L % (2 << t)) == 0) begin : g_path
        assign pv[t]  = acc[L + (1 << t)];
        assign has[t] = 1'b1;
      end else begin : g_nopath
        assign pv[t]  = '0;
        assign has[t] = 1'b0;
      end
    end

    assign tree_take = tree_act && has[lvl_q];

    tvr_lane #(.ELEM_W(ELEM_W), .IS_EVEN((L % 2) == 0)) u_lane (
      .clk(clk), .rst_n(rst_n), .init(init), .init_val(init_val),
      .fold_take(fold_take),
      .fold_elem(rd_data[(L/2)*REG_W + (L%2)*ELEM_W +: ELEM_W]),
      .tree_take(tree_take), .partner(pv[lvl_q]), .op(op_q), .acc(acc[L])
    );
  end

  assign rd_en  = fold_act;
  assign result = acc[0];
  assign wb_we  = done;

  AST_NO_READ_WHILE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en); // R3
  AST_DONE_AFTER_TREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(tree_act)); // R6
endmodule

// File: tb/tree_vec_reducer_test.sv
module tree_vec_reducer_test;
  localparam int LANES  = 8;
  localparam int ELEM_W = 16;
  localparam int N_W    = 6;
  localparam int AW     = 5;
  localparam int RP     = LANES / 2;
  localparam int NREGS  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N_W-1:0] n_elems = '0;
  logic [1:0] op = '0;
  logic rd_en;
  logic [RP*AW-1:0] rd_addr;
  logic [RP*2*ELEM_W-1:0] rd_data;
  logic [ELEM_W-1:0] result;
  logic done, wb_we;

  logic [2*ELEM_W-1:0] regs [NREGS];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int cur_start = 0;
  bit prev_done = 1'b0;
  logic [ELEM_W-1:0] sb_res [$];
  int sb_cyc [$];
  int sb_tag [$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tree_vec_reducer #(.LANES(LANES), .ELEM_W(ELEM_W), .N_W(N_W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems), .op(op),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .result(result),
    .done(done), .wb_we(wb_we)
  );

  always_comb begin
    for (int j = 0; j < RP; j++)
      rd_data[j*2*ELEM_W +: 2*ELEM_W] = regs[rd_addr[j*AW +: AW]];
  end

  function automatic logic [ELEM_W-1:0] serial_ref(input int n, input int o);
    logic [ELEM_W-1:0] a, e;
    a = (o == 1) ? '1 : '0;
    for (int i = 0; i < n; i++) begin
      e = regs[i/2][(i%2)*ELEM_W +: ELEM_W];
      case (o)
        0: a = a + e;
        1: a = a & e;
        2: a = a | e;
        default: a = a ^ e;
      endcase
    end
    return a;
  endfunction

  task automatic report(input int tag, input string what, input int act, input int exp);
    case (tag)
      2: $display("FAIL R2 %s: actual=%h expected=%h", what, act, exp);
      4: $display("FAIL R4 %s: actual=%h expected=%h", what, act, exp);
      5: $display("FAIL R5 %s: actual=%h expected=%h", what, act, exp);
      default: $display("FAIL R8 %s: actual=%h expected=%h", what, act, exp);
    endcase
  endtask

  // driver: pushes expected items and pulses start
  task automatic run_vec(input int n, input int o, input bit poke);
    int npass;
    int tag;
    for (int r = 0; r < NREGS; r++) regs[r] = $urandom;
    npass = (n + LANES - 1) / LANES;
    if (npass == 0) npass = 1;
    tag = poke ? 8 : (n == 0) ? 5 : (n % LANES != 0) ? 4 : 2;
    @(negedge clk);
    start = 1'b1; n_elems = N_W'(n); op = 2'(o);
    cur_start = cyc;
    sb_res.push_back(serial_ref(n, o));
    sb_cyc.push_back(cyc + npass + 4);
    sb_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0; n_elems = N_W'($urandom); op = 2'($urandom);
    if (poke) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    do @(posedge clk); while (sb_res.size() != 0);
  endtask

  // monitor: compares results as they appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_en) begin
        for (int j = 0; j < RP; j++) begin
          checks++;
          if (int'(rd_addr[j*AW +: AW]) != ((cyc - cur_start - 1) * RP + j) % NREGS) begin
            fails++;
            $display("FAIL R3 port %0d address: actual=%0d expected=%0d", j,
                     rd_addr[j*AW +: AW], ((cyc - cur_start - 1) * RP + j) % NREGS);
          end
        end
      end
      if (done || wb_we) begin
        checks++;
        if (done != wb_we) begin
          fails++;
          $display("FAIL R7 strobe: actual=%0d expected=%0d", wb_we, done);
        end
      end
      if (done) begin
        checks++;
        if (prev_done) begin
          fails++;
          $display("FAIL R7 done width: actual=%0d expected=%0d", 2, 1);
        end
        if (sb_res.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6 unexpected done: actual=%0d expected=%0d", 1, 0);
        end else begin
          logic [ELEM_W-1:0] er;
          int ec, et;
          er = sb_res.pop_front(); ec = sb_cyc.pop_front(); et = sb_tag.pop_front();
          checks++;
          if (result !== er) begin
            fails++;
            report(et, "result", int'(result), int'(er));
          end
          checks++;
          if (cyc != ec) begin
            fails++;
            $display("FAIL R6 done cycle: actual=%0d expected=%0d", cyc, ec);
          end
        end
      end
      prev_done = done;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NREGS; r++) regs[r] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || wb_we !== 1'b0 || rd_en !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1 reset state: actual=%b%b%b/%h expected=000/0000",
               done, wb_we, rd_en, result);
    end
    // R2 R4 R5: every count 0..32 under each operation
    for (int o = 0; o < 4; o++)
      for (int n = 0; n <= 32; n++)
        run_vec(n, o, 1'b0);
    // R3: full-length vector touching every register
    for (int o = 0; o < 4; o++) run_vec(63, o, 1'b0);
    // R8: start while busy
    run_vec(5, 0, 1'b1);
    run_vec(17, 1, 1'b1);
    run_vec(32, 3, 1'b1);
    run_vec(1, 2, 1'b1);
    repeat (4) @(negedge clk);
    checks++;
    if (sb_res.size() != 0) begin
      fails++;
      $display("FAIL R6 pending results: actual=%0d expected=%0d", sb_res.size(), 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule